// File: doc/BRIEF.md
# Legacy Interrupt Pending and Enable Register

This block collects four level-sensitive legacy interrupt lines into one 32-bit control word that software reads and writes. Each line has a sticky pending flag and an enable flag. While any line is both pending and enabled, the block drives a single shared interrupt towards a parent interrupt controller. Software acknowledges a line by writing a 1 to its pending flag. Writing 0 leaves a pending flag untouched, so a read-modify-write that zeroes the pending field cannot drop an interrupt that is still waiting.

The same word also holds plain read/write storage for the bus-error mask flags, the request-line priority flags and a target-ready wait value. Writes go through per-byte lane enables. This lets one halfword write to the upper half acknowledge every line and mask every line in a single access at start-up.

Top module: `intx_ctl_unit`

## Requirements
- R1: After reset, every bit of `rd_data` reads 0 and `irq_out` is low.
- R2: At each rising clock edge where line i of `intx_in` is high, the pending flag at bit 28+i is set. It stays set after the line falls.
- R3: A write with byte lane 3 enabled clears every pending flag whose data bit (28+i) is 1. A pending flag whose data bit is 0 keeps its value.
- R4: An acknowledge wins in the cycle of the write, so the flag reads 0 right after it. If the line is still high, the flag sets again at the next clock edge.
- R5: The enable for line i sits at bit 22+i; 1 passes the line and 0 masks it. `irq_out` is high exactly when some line is both pending and enabled. A pending line that is masked does not raise `irq_out`.
- R6: The error-mask bits 27, 26 and 21:16 are plain read/write storage.
- R7: The priority bits 14:8 and the wait value in bits 3:0 are plain read/write storage. Reserved bits 15 and 7:4 always read 0.
- R8: `wr_be[k]` gates bits 8k+7 down to 8k. Bits in a lane whose enable is 0 keep their value.
- R9: A write of 0xF000_0000 with `wr_be` = 4'b1100 clears all four pending flags and all four enables in one cycle. The lower halfword is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_in | input | 4 | Level-sensitive interrupt lines, line i on bit i |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
On every cycle, the embedded properties check the following:
- the sticky set, hold and acknowledge behaviour of each pending flag;
- that `irq_out` agrees with the pending and enable fields read back from the register;
- that storage lanes hold their value when their lane is not written;
- the zero state after reset.

Some behaviours only the directed scenarios can show:
- the one-cycle gap before a line that is still high sets its flag again after an acknowledge;
- that zeros written to the pending field do no harm;
- the exact field layout of the plain storage;
- the single-access start-up sequence that clears and masks while the lower halfword is preserved.

// File: rtl/intx_ctl_pkg.sv
package intx_ctl_pkg;

    localparam int REG_W      = 32;
    localparam int LANES      = REG_W / 8;
    localparam int NUM_LINES  = 4;
    localparam int STAT_LSB   = 28;
    localparam int EN_LSB     = 22;
    localparam int ERR_HI_LSB = 26;
    localparam int ERR_HI_W   = 2;
    localparam int ERR_LO_LSB = 16;
    localparam int ERR_LO_W   = 6;
    localparam int PRIO_LSB   = 8;
    localparam int PRIO_W     = 7;
    localparam int WAIT_LSB   = 0;
    localparam int WAIT_W     = 4;

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] be;
        logic [REG_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [ERR_HI_W-1:0] err_hi;
        logic [ERR_LO_W-1:0] err_lo;
        logic [PRIO_W-1:0]   prio;
        logic [WAIT_W-1:0]   trdy_wait;
    } ctl_fields_t;

    // Expand byte-lane enables into a bit mask, gated by the strobe.
    function automatic logic [REG_W-1:0] lane_mask(input wr_req_t r);
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < LANES; k++) begin
            m[k*8 +: 8] = {8{r.valid & r.be[k]}};
        end
        return m;
    endfunction

    // Place the storage fields at their register positions.
    function automatic logic [REG_W-1:0] ctl_to_word(input ctl_fields_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[ERR_HI_LSB +: ERR_HI_W] = c.err_hi;
        w[ERR_LO_LSB +: ERR_LO_W] = c.err_lo;
        w[PRIO_LSB   +: PRIO_W]   = c.prio;
        w[WAIT_LSB   +: WAIT_W]   = c.trdy_wait;
        return w;
    endfunction

    // Pull the storage fields out of a register word.
    function automatic ctl_fields_t word_to_ctl(input logic [REG_W-1:0] w);
        ctl_fields_t c;
        c.err_hi    = w[ERR_HI_LSB +: ERR_HI_W];
        c.err_lo    = w[ERR_LO_LSB +: ERR_LO_W];
        c.prio      = w[PRIO_LSB   +: PRIO_W];
        c.trdy_wait = w[WAIT_LSB   +: WAIT_W];
        return c;
    endfunction

endpackage

// File: rtl/intx_line_slice.sv
module intx_line_slice
    import intx_ctl_pkg::*;
#(
    parameter int STAT_POS = 28,
    parameter int EN_POS   = 22
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    line_in,
    input  wr_req_t req,
    output logic    pend,
    output logic    en
);
    localparam int STAT_LANE = STAT_POS / 8;
    localparam int EN_LANE   = EN_POS / 8;

    logic clr;
    logic en_wr;

    assign clr   = req.valid & req.be[STAT_LANE] & req.data[STAT_POS];
    assign en_wr = req.valid & req.be[EN_LANE];

    // An acknowledge wins over a set in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            en   <= 1'b0;
        end else begin
            if (clr)          pend <= 1'b0;
            else if (line_in) pend <= 1'b1;
            if (en_wr)        en   <= req.data[EN_POS];
        end
    end

    // R2: a high line sets the flag
    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (line_in && !clr) |=> pend);
    // R2: the flag is sticky
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);
    // R3 and R4: an acknowledge clears the flag
    assert_ack_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pend);
    // R3: the flag does not set by itself
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!pend && !line_in) |=> !pend);
    // R8: the enable holds while its lane is not written
    assert_en_keep_R8: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en));

endmodule

// File: rtl/intx_ctl_store.sv
module intx_ctl_store
    import intx_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_req_t     req,
    output ctl_fields_t ctl
);
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] cur_w;
    logic [REG_W-1:0] nxt_w;

    assign mask  = lane_mask(req);
    assign cur_w = ctl_to_word(ctl);
    assign nxt_w = (cur_w & ~mask) | (req.data & mask);

    always_ff @(posedge clk) begin
        if (rst) ctl <= '0;
        else     ctl <= word_to_ctl(nxt_w);
    end

    // R8: the priority lane holds without a write to lane 1
    assert_prio_keep_R8: assert property (@(posedge clk) disable iff (rst)
        !(req.valid && req.be[1]) |=> $stable(ctl.prio));
    // R8: the wait lane holds without a write to lane 0
    assert_wait_keep_R8: assert property (@(posedge clk) disable iff (rst)
        !(req.valid && req.be[0]) |=> $stable(ctl.trdy_wait));
    // R6: the error masks take the written value
    assert_err_load_R6: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.be[3] && req.be[2]) |=>
        (ctl.err_hi == $past(req.data[ERR_HI_LSB +: ERR_HI_W]) &&
         ctl.err_lo == $past(req.data[ERR_LO_LSB +: ERR_LO_W])));

endmodule

// File: rtl/intx_merge.sv
module intx_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    output logic         irq
);
    logic [N:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_or
        assign chain[i+1] = chain[i] | (pend[i] & en[i]);
    end
    assign irq = chain[N];

endmodule

// File: rtl/intx_ctl_unit.sv
module intx_ctl_unit
    import intx_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] intx_in,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     wr_be,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic                 irq_out
);
    wr_req_t              req;
    ctl_fields_t          ctl;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] en;

    assign req.valid = wr_en;
    assign req.be    = wr_be;
    assign req.data  = wr_data;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        intx_line_slice #(
            .STAT_POS(STAT_LSB + i),
            .EN_POS  (EN_LSB + i)
        ) u_slice (
            .clk    (clk),
            .rst    (rst),
            .line_in(intx_in[i]),
            .req    (req),
            .pend   (pend[i]),
            .en     (en[i])
        );
    end

    intx_ctl_store u_store (
        .clk(clk),
        .rst(rst),
        .req(req),
        .ctl(ctl)
    );

    intx_merge #(.N(NUM_LINES)) u_merge (
        .pend(pend),
        .en  (en),
        .irq (irq_out)
    );

    always_comb begin
        rd_data = ctl_to_word(ctl);
        rd_data[STAT_LSB +: NUM_LINES] = pend;
        rd_data[EN_LSB   +: NUM_LINES] = en;
    end

    // R1: the word is zero right after reset
    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0 && !irq_out));
    // R5: the output agrees with the fields read back
    assert_irq_match_R5: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(rd_data[STAT_LSB +: NUM_LINES] & rd_data[EN_LSB +: NUM_LINES]));
    // R5: no enable means no output
    assert_masked_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_data[EN_LSB +: NUM_LINES] == '0) |-> !irq_out);

endmodule

// File: tb/sim_intx_ctl_unit.sv
module sim_intx_ctl_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  intx_in;
    logic        wr_en;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq_out;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    intx_ctl_unit u0 (
        .clk(clk), .rst(rst), .intx_in(intx_in), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic pulse_lines(input logic [3:0] l);
        @(negedge clk);
        intx_in = l;
        @(negedge clk);
        intx_in = '0;
    endtask

    task automatic t_reset;
        rst = 1'b1; intx_in = '0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 word", rd_data, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_sticky;
        pulse_lines(4'b1011);
        check("R2 set", rd_data, 32'hB000_0000);
        @(negedge clk);
        check("R2 sticky", rd_data, 32'hB000_0000);
        check("R5 masked pending", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_ack;
        reg_write(4'b1000, 32'h2000_0000);
        check("R3 ack one", rd_data, 32'h9000_0000);
        reg_write(4'b1000, 32'h0000_0000);
        check("R3 zero keeps", rd_data, 32'h9000_0000);
        reg_write(4'b1000, 32'h9000_0000);
        check("R3 ack rest", rd_data, 32'h0);
    endtask

    task automatic t_reassert;
        @(negedge clk);
        intx_in = 4'b0010;
        @(negedge clk);
        check("R4 set", rd_data, 32'h2000_0000);
        wr_en = 1'b1; wr_be = 4'b1000; wr_data = 32'h2000_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
        check("R4 ack wins", rd_data, 32'h0);
        @(negedge clk);
        check("R4 sets again", rd_data, 32'h2000_0000);
        intx_in = '0;
        reg_write(4'b1000, 32'h2000_0000);
        check("R4 cleared", rd_data, 32'h0);
    endtask

    task automatic t_mask;
        reg_write(4'b0100, 32'h0040_0000);
        check("R5 enable line0", rd_data, 32'h0040_0000);
        pulse_lines(4'b0010);
        check("R5 masked no irq", {31'b0, irq_out}, 32'h0);
        pulse_lines(4'b0001);
        check("R5 enabled irq", {31'b0, irq_out}, 32'h1);
        reg_write(4'b1000, 32'h1000_0000);
        check("R5 irq drops", {31'b0, irq_out}, 32'h0);
        reg_write(4'b1100, 32'h2000_0000);
        check("R5 all masked", rd_data, 32'h0);
    endtask

    task automatic t_storage;
        reg_write(4'b1111, 32'hFFFF_FFFF);
        check("R6 R7 fill", rd_data, 32'h0FFF_7F0F);
        reg_write(4'b1111, 32'h0000_0000);
        check("R6 R7 empty", rd_data, 32'h0);
        reg_write(4'b0011, 32'h0000_A5C3);
        check("R7 prio wait", rd_data, 32'h0000_2503);
    endtask

    task automatic t_lanes;
        reg_write(4'b1111, 32'h0FFF_7F0F);
        reg_write(4'b0010, 32'h0);
        check("R8 lane1", rd_data, 32'h0FFF_000F);
        reg_write(4'b0001, 32'h0);
        check("R8 lane0", rd_data, 32'h0FFF_0000);
        reg_write(4'b0100, 32'h0);
        check("R8 lane2", rd_data, 32'h0F00_0000);
    endtask

    task automatic t_startup;
        reg_write(4'b1111, 32'h03C0_1A05);
        pulse_lines(4'b1111);
        check("R9 before", rd_data, 32'hF3C0_1A05);
        check("R9 irq before", {31'b0, irq_out}, 32'h1);
        reg_write(4'b1100, 32'hF000_0000);
        check("R9 after", rd_data, 32'h0000_1A05);
        check("R9 irq after", {31'b0, irq_out}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_sticky();
        t_ack();
        t_reassert();
        t_mask();
        t_storage();
        t_lanes();
        t_startup();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule